// File: doc/BRIEF.md
# LCD Panel Pin Launch Stage

This block sits between a raster timing generator and the pins of an LCD panel. It receives an active-high line sync, an active-high frame sync, an active-high data-enable (AC-bias) strobe and a pixel word. All of them arrive from the pixel clock domain and are stable around the rising pixel-clock edge. Each output is launched from either the rising or the falling edge of the pixel clock, and each control output gets its own polarity.

The pixel word and the control strobes always leave on opposite edges. A single swap bit decides which group takes the rising edge. The two sync outputs can be moved off the control edge and placed on an edge of their own. A mode bit marks passive-matrix (STN) panels. In that mode the data-enable inversion is disregarded.

The configuration is taken into an internal register in two cases: during reset, and in the cycle where the frame sync input rises. A change made at any other time waits for the next frame. This keeps a polarity change from cutting a line in two.

Top module: `lcd_pin_stage`

## Requirements
- R1: With `cfg_swap_edge` = 0, `pix_o` changes only after a rising `clk` edge, and `de_o` changes only after a falling edge.
- R2: With `cfg_swap_edge` = 1, `pix_o` changes only after a falling `clk` edge, and `de_o` changes only after a rising edge.
- R3: With `cfg_sync_sel` = 0, `line_o` and `frame_o` use the same edge as `de_o`, and `cfg_sync_fall` has no effect.
- R4: With `cfg_sync_sel` = 1, `line_o` and `frame_o` change after the rising edge when `cfg_sync_fall` = 0, and after the falling edge when it is 1.
- R5: `line_o` equals `line_i` XOR `cfg_line_low`, launched one edge after `line_i` is sampled on the rising edge. A value of 1 in `cfg_line_low` makes the output active low.
- R6: `frame_o` equals `frame_i` XOR `cfg_frame_low`.
- R7: `de_o` equals `de_i` XOR (`cfg_de_low` AND NOT `cfg_stn`). In STN mode (`cfg_stn` = 1) the data-enable output is never inverted.
- R8: While `rst` is high (synchronous, active high), `pix_o` is 0 and each control output sits at its inactive level under the configuration presented during reset: `line_o` = `cfg_line_low`, `frame_o` = `cfg_frame_low`, `de_o` = `cfg_de_low` AND NOT `cfg_stn`.
- R9: The configuration is captured during reset and on the rising edge where `frame_i` is 1 after being 0. That captured value already governs the values launched from that edge. Configuration changes at any other time have no effect on any output until the next such capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_sel | input | 1 | 1: syncs use their own edge choice |
| cfg_sync_fall | input | 1 | Sync edge when cfg_sync_sel=1 (0 rising, 1 falling) |
| cfg_swap_edge | input | 1 | 0: data rising / controls falling; 1: swapped |
| cfg_line_low | input | 1 | Line sync active low |
| cfg_frame_low | input | 1 | Frame sync active low |
| cfg_de_low | input | 1 | Data-enable active low (TFT only) |
| cfg_stn | input | 1 | Passive-matrix panel mode |
| line_i | input | 1 | Internal line sync, active high |
| frame_i | input | 1 | Internal frame sync, active high |
| de_i | input | 1 | Internal data-enable / AC bias, active high |
| pix_i | input | PIX_W | Pixel word |
| line_o | output | 1 | Line sync pin |
| frame_o | output | 1 | Frame sync pin |
| de_o | output | 1 | Data-enable / AC-bias pin |
| pix_o | output | PIX_W | Pixel data pins |

## Verification
Two things can happen on the same rising edge: a configuration capture, and the launch of the frame-sync pulse that caused it. Some outputs still carry a value launched under the old polarity until the following falling edge. The bench provokes this in every configuration. It raises `frame_i` with a fresh configuration on the inputs and then compares each pin twice, one nanosecond after the rising edge and one after the falling edge. On the rising-edge sample, the bench expects rising-launched pins to show the new value under the new polarity. Pins launched on the falling edge must still hold the previous value under the previous polarity.

// File: rtl/lcd_pin_pkg.sv
package lcd_pin_pkg;

    localparam int PIX_W_DEF = 16;
    localparam int CTL_W     = 3;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_e;

    typedef struct packed {
        logic sync_sel;
        logic sync_fall;
        logic swap_edge;
        logic line_low;
        logic frame_low;
        logic de_low;
        logic stn;
    } pin_cfg_t;

    typedef struct packed {
        logic line;
        logic frame;
        logic de;
    } ctl_t;

    // Bits set where the pin is active low; equals the idle level of each pin.
    function automatic ctl_t ctl_polarity(input pin_cfg_t c);
        ctl_t m;
        m.line  = c.line_low;
        m.frame = c.frame_low;
        m.de    = c.de_low & ~c.stn;
        return m;
    endfunction

    function automatic edge_e data_edge(input pin_cfg_t c);
        return c.swap_edge ? EDGE_FALL : EDGE_RISE;
    endfunction

    function automatic edge_e ctrl_edge(input pin_cfg_t c);
        return c.swap_edge ? EDGE_RISE : EDGE_FALL;
    endfunction

    function automatic edge_e sync_edge(input pin_cfg_t c);
        if (c.sync_sel)
            return c.sync_fall ? EDGE_FALL : EDGE_RISE;
        return ctrl_edge(c);
    endfunction

endpackage

// File: rtl/lcd_cfg_latch.sv
module lcd_cfg_latch
    import lcd_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_in,
    input  pin_cfg_t cfg_in,
    output pin_cfg_t cfg_eff,
    output pin_cfg_t cfg_q
);

    logic frame_seen;
    logic take;

    assign take    = rst | (frame_in & ~frame_seen);
    assign cfg_eff = take ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) frame_seen <= 1'b0;
        else     frame_seen <= frame_in;
        cfg_q <= cfg_eff;
    end

    // Without a fresh frame start, the captured configuration must not move.
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!frame_in || frame_seen) |=> $stable(cfg_q));

endmodule

// File: rtl/lcd_launch_bank.sv
module lcd_launch_bank #(
    parameter int W       = 8,
    parameter bit FALLING = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) q <= rst_val;
                else     q <= d;
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) q <= rst_val;
                else     q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/lcd_edge_mux.sv
module lcd_edge_mux
    import lcd_pin_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [W-1:0] rise_q,
    input  logic [W-1:0] fall_q,
    input  edge_e        sel,
    output logic [W-1:0] y
);

    always_comb begin
        y = (sel == EDGE_FALL) ? fall_q : rise_q;
    end

endmodule

// File: rtl/lcd_pin_stage.sv
module lcd_pin_stage
    import lcd_pin_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_sync_sel,
    input  logic             cfg_sync_fall,
    input  logic             cfg_swap_edge,
    input  logic             cfg_line_low,
    input  logic             cfg_frame_low,
    input  logic             cfg_de_low,
    input  logic             cfg_stn,
    input  logic             line_i,
    input  logic             frame_i,
    input  logic             de_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             line_o,
    output logic             frame_o,
    output logic             de_o,
    output logic [PIX_W-1:0] pix_o
);

    localparam int BANK_W = CTL_W + PIX_W;

    pin_cfg_t cfg_in, cfg_eff, cfg_q;
    ctl_t     ctl_in, ctl_pol, ctl_idle_q;
    ctl_t     ctl_rise, ctl_fall, ctl_out;
    logic [BANK_W-1:0] rise_d, rise_rst, rise_q, fall_rst, fall_q;
    logic [PIX_W-1:0]  pix_rise, pix_fall;
    edge_e    ctl_sel [CTL_W];

    assign cfg_in = '{sync_sel:  cfg_sync_sel,  sync_fall: cfg_sync_fall,
                      swap_edge: cfg_swap_edge, line_low:  cfg_line_low,
                      frame_low: cfg_frame_low, de_low:    cfg_de_low,
                      stn:       cfg_stn};

    lcd_cfg_latch u_cfg (
        .clk      (clk),
        .rst      (rst),
        .frame_in (frame_i),
        .cfg_in   (cfg_in),
        .cfg_eff  (cfg_eff),
        .cfg_q    (cfg_q)
    );

    assign ctl_in     = '{line: line_i, frame: frame_i, de: de_i};
    assign ctl_pol    = ctl_polarity(cfg_eff);
    assign ctl_idle_q = ctl_polarity(cfg_q);

    // Polarity is applied once, ahead of both banks.
    assign rise_d   = {ctl_in ^ ctl_pol, pix_i};
    assign rise_rst = {ctl_pol, {PIX_W{1'b0}}};
    assign fall_rst = {ctl_idle_q, {PIX_W{1'b0}}};

    lcd_launch_bank #(.W(BANK_W), .FALLING(1'b0)) u_rise (
        .clk     (clk),
        .rst     (rst),
        .d       (rise_d),
        .rst_val (rise_rst),
        .q       (rise_q)
    );

    lcd_launch_bank #(.W(BANK_W), .FALLING(1'b1)) u_fall (
        .clk     (clk),
        .rst     (rst),
        .d       (rise_q),
        .rst_val (fall_rst),
        .q       (fall_q)
    );

    assign ctl_rise = ctl_t'(rise_q[BANK_W-1:PIX_W]);
    assign ctl_fall = ctl_t'(fall_q[BANK_W-1:PIX_W]);
    assign pix_rise = rise_q[PIX_W-1:0];
    assign pix_fall = fall_q[PIX_W-1:0];

    // Lane order inside ctl_t: [2] line, [1] frame, [0] de.
    assign ctl_sel[2] = sync_edge(cfg_q);
    assign ctl_sel[1] = sync_edge(cfg_q);
    assign ctl_sel[0] = ctrl_edge(cfg_q);

    generate
        for (genvar k = 0; k < CTL_W; k++) begin : g_ctl
            lcd_edge_mux #(.W(1)) u_mux (
                .rise_q (ctl_rise[k]),
                .fall_q (ctl_fall[k]),
                .sel    (ctl_sel[k]),
                .y      (ctl_out[k])
            );
        end
    endgenerate

    lcd_edge_mux #(.W(PIX_W)) u_pix_mux (
        .rise_q (pix_rise),
        .fall_q (pix_fall),
        .sel    (data_edge(cfg_q)),
        .y      (pix_o)
    );

    assign line_o  = ctl_out.line;
    assign frame_o = ctl_out.frame;
    assign de_o    = ctl_out.de;

    // Rising-launched data shows the word sampled on the previous rising edge.
    assert_pix_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cfg_q.swap_edge) |-> pix_o == $past(pix_i));

    assert_de_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_q.swap_edge)
        |-> de_o == ($past(de_i) ^ (cfg_q.de_low & ~cfg_q.stn)));

    assert_sync_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !cfg_q.sync_sel && cfg_q.swap_edge)
        |-> (line_o == ($past(line_i) ^ cfg_q.line_low)) &&
            (frame_o == ($past(frame_i) ^ cfg_q.frame_low)));

    assert_sync_own_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_q.sync_sel && !cfg_q.sync_fall)
        |-> (line_o == ($past(line_i) ^ cfg_q.line_low)) &&
            (frame_o == ($past(frame_i) ^ cfg_q.frame_low)));

    assert_de_stn_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && cfg_q.stn && cfg_q.swap_edge) |-> de_o == $past(de_i));

    assert_reset_idle_R8: assert property (@(posedge clk)
        (rst && $past(rst) && $stable(cfg_q))
        |-> (pix_o == '0) && (line_o == cfg_q.line_low) &&
            (frame_o == cfg_q.frame_low) &&
            (de_o == (cfg_q.de_low & ~cfg_q.stn)));

endmodule

// File: tb/tb_lcd_pin_stage.sv
module tb_lcd_pin_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  cur_cfg = '0;   // {sync_sel, sync_fall, swap, line_low, frame_low, de_low, stn}
    logic        line_i = 1'b0, frame_i = 1'b0, de_i = 1'b0;
    logic [15:0] pix_i = '0;
    logic        line_o, frame_o, de_o;
    logic [15:0] pix_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [6:0]  act;
    logic        last_f;
    logic        old_l, old_f, old_d;
    logic [15:0] old_p;
    string       tag_force = "";

    always #10 clk = ~clk;

    lcd_pin_stage #(.PIX_W(16)) dut (
        .clk           (clk),
        .rst           (rst),
        .cfg_sync_sel  (cur_cfg[6]),
        .cfg_sync_fall (cur_cfg[5]),
        .cfg_swap_edge (cur_cfg[4]),
        .cfg_line_low  (cur_cfg[3]),
        .cfg_frame_low (cur_cfg[2]),
        .cfg_de_low    (cur_cfg[1]),
        .cfg_stn       (cur_cfg[0]),
        .line_i        (line_i),
        .frame_i       (frame_i),
        .de_i          (de_i),
        .pix_i         (pix_i),
        .line_o        (line_o),
        .frame_o       (frame_o),
        .de_o          (de_o),
        .pix_o         (pix_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] actual, input logic [15:0] expect_v);
        string t;
        t = (tag_force != "") ? tag_force : tag;
        n_checks++;
        if (actual !== expect_v) begin
            n_errors++;
            $display("FAIL %s %s actual %h expected %h (cfg %b)", t, what, actual, expect_v, act);
        end
    endtask

    // Called at negedge + 1 ns; applies one input set and judges both edges.
    task automatic step(input logic l, input logic f, input logic d, input logic [15:0] px);
        logic nl, nf, nd;
        logic pix_r, de_r, sync_r;
        string tl, tp;
        if (f && !last_f) act = cur_cfg;   // R9 capture at frame start
        last_f  = f;
        line_i  = l; frame_i = f; de_i = d; pix_i = px;
        nl = l ^ act[3];
        nf = f ^ act[2];
        nd = d ^ (act[1] & ~act[0]);
        pix_r  = ~act[4];
        de_r   = act[4];
        sync_r = act[6] ? ~act[5] : act[4];
        tl = act[6] ? "R4" : "R3";
        tp = act[4] ? "R2" : "R1";
        @(posedge clk); #1;
        check(tp,   "pix@rise",   pix_o,          pix_r  ? px : old_p);
        check("R5", "line@rise",  {15'd0, line_o},  {15'd0, sync_r ? nl : old_l});
        check(tl,   "frame@rise", {15'd0, frame_o}, {15'd0, sync_r ? nf : old_f});
        check("R7", "de@rise",    {15'd0, de_o},    {15'd0, de_r ? nd : old_d});
        @(negedge clk); #1;
        check(tp,   "pix@fall",   pix_o,            px);
        check("R5", "line@fall",  {15'd0, line_o},  {15'd0, nl});
        check("R6", "frame@fall", {15'd0, frame_o}, {15'd0, nf});
        check("R7", "de@fall",    {15'd0, de_o},    {15'd0, nd});
        old_l = nl; old_f = nf; old_d = nd; old_p = px;
    endtask

    task automatic do_reset(input logic [6:0] c);
        @(negedge clk); #1;
        rst = 1'b1; cur_cfg = c;
        line_i = 0; frame_i = 0; de_i = 0; pix_i = '0;
        repeat (3) @(negedge clk);
        #1;
        act = c;
        check("R8", "pix@reset",   pix_o,            16'd0);
        check("R8", "line@reset",  {15'd0, line_o},  {15'd0, c[3]});
        check("R8", "frame@reset", {15'd0, frame_o}, {15'd0, c[2]});
        check("R8", "de@reset",    {15'd0, de_o},    {15'd0, c[1] & ~c[0]});
        rst = 1'b0;
        last_f = 1'b0;
        old_l = c[3]; old_f = c[2]; old_d = c[1] & ~c[0]; old_p = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        do_reset(7'b0011110);    // R8 with all inversions, TFT
        step(1'b1, 1'b0, 1'b1, 16'h1234);
        do_reset(7'b0001011);    // R8: STN masks de inversion

        // Sweep every configuration; each begins with a frame start (R9).
        for (int c = 0; c < 128; c++) begin
            cur_cfg = 7'(c);
            step(1'b0, 1'b0, 1'b0, 16'(c * 613));
            step(1'b1, 1'b1, 1'b1, 16'(c * 613 + 17));
            for (int i = 0; i < 4; i++) begin
                step(logic'(i[0] ^ c[0]), logic'(i[1]), logic'(~i[0]),
                     16'(c * 613 + i * 4111 + 1));
            end
        end

        // R9: changes inside a frame are ignored until the next frame start.
        cur_cfg = 7'b0000000;
        step(1'b0, 1'b0, 1'b0, 16'h0F0F);
        step(1'b0, 1'b1, 1'b0, 16'hF0F0);
        tag_force = "R9";
        cur_cfg = 7'b0011110;
        for (int i = 0; i < 4; i++)
            step(logic'(i[0]), 1'b1, logic'(i[1]), 16'(16'hA5A5 ^ i));
        step(1'b1, 1'b0, 1'b1, 16'h5A5A);
        step(1'b0, 1'b1, 1'b0, 16'h3C3C);   // new config now takes hold
        step(1'b1, 1'b1, 1'b1, 16'hC3C3);
        tag_force = "";

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule